// File: doc/BRIEF.md
# Background Memory Scrub Engine

The scrub engine sits next to a memory controller and steps through a window of word addresses. The window runs from a programmed base address to base plus a programmed inclusive offset. Software sets up the engine through a small register port. It then starts the engine with an enable bit. Memory traffic leaves through a request/ready port, and a single-cycle response pulse comes back for every accepted request.

The engine has two modes. In fill mode it writes a programmed 32-bit word to every location in the window exactly once. This prepares error-protected memory. While the fill runs, the engine asks the controller to hold off host traffic. In patrol mode it reads the window again and again, wrapping from the last address back to the base. An interval field sets the number of idle cycles between reads, so the controller can find and repair errors in the background.

Control is a state machine with five states:
- `ST_IDLE`: waiting for enable.
- `ST_ISSUE`: a request is presented.
- `ST_GAP`: patrol pacing.
- `ST_DRAIN`: waiting for in-flight responses.
- `ST_HOLD`: fill finished, waiting for enable to clear.

The transitions are:
- idle to issue on enable.
- issue to gap after an accepted patrol read with a non-zero interval.
- gap to issue when the pacing count ends.
- issue to drain when the last fill write is accepted, or when enable is cleared.
- gap to drain when enable is cleared.
- drain to hold when a completed fill drains with enable still set.
- drain to idle in every other case.
- hold to idle when enable is cleared.

Top module: `scrub_engine`

## Requirements
- R1: After reset, every register reads zero, and `mem_req` and `host_hold` are low.
- R2: Register offsets are fixed:
  - 0: control. Bit 0 is enable, bit 2 is mode (1 = fill, 0 = patrol), bits 15:8 are the interval. Other bits read zero.
  - 1: status, read only. Bit 1 is done, bit 0 is busy.
  - 2: window base.
  - 3: window inclusive offset.
  - 4: fill word.
- R3: In fill mode, every address from base to base+offset is written once with the fill word. No location outside the window is written, and no request follows the last write.
- R4: Done sets when the last fill write is accepted, and stays set until enable is cleared. Busy clears only when no response is outstanding, so done is seen while busy is still high.
- R5: In patrol mode, reads go base, base+1, …, base+offset, then wrap to base and continue without end.
- R6: With ready held high, successive patrol reads are accepted interval×4+1 cycles apart. Interval 0 gives back-to-back reads.
- R7: Clearing enable mid-pass drops requests from the next cycle. Busy then clears once in-flight responses return, and done stays zero.
- R8: While busy, writes to base, offset, mode and interval are ignored. The enable bit stays writable.
- R9: `host_hold` is high while a fill is busy. It is low in patrol mode and after a fill has drained.
- R10: A request held off by a low `mem_ready` keeps its address until it is accepted. The fill still writes each location exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (fill mode) |
| mem_addr | output | 16 | Request word address |
| mem_wdata | output | 32 | Fill word |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp | input | 1 | One earlier request completed |
| host_hold | output | 1 | Asks the controller to block host traffic |

## Verification
Fill mode is driven from a table of windows:
- An eight-word window at address zero.
- A single-word window, where base equals the last address.
- A thirteen-word window.
- A window ending at the top of the modelled memory.

Half of these run with a ready line that toggles every cycle. This tells whether the engine double-writes a location or skips one under backpressure, and whether it writes outside the window.

Patrol mode is tried with interval 1 and interval 0. Comparing the address sequence and the accept spacing between these two runs separates the wrap logic from the pacing logic.

Directed runs cover three further cases:
- An abort part-way through a fill.
- Writes to locked registers while the engine is busy.
- The done-before-busy ordering set by response latency.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_START = 3'd2;
    localparam logic [REG_AW-1:0] OFS_RANGE = 3'd3;
    localparam logic [REG_AW-1:0] OFS_PATT  = 3'd4;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MODE_BIT = 2;
    localparam int CTL_IV_LSB   = 8;

    localparam int STA_BUSY_BIT = 0;
    localparam int STA_DONE_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_DRAIN,
        ST_HOLD
    } scrub_state_t;

endpackage

// File: rtl/scrub_regs.sv
`timescale 1ns/1ps
module scrub_regs
    import scrub_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int IVW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic              en,
    output logic              mode_wr,
    output logic [IVW-1:0]    interval,
    output logic [AW-1:0]     win_start,
    output logic [AW-1:0]     win_range,
    output logic [DW-1:0]     pattern,
    output logic [DW-1:0]     reg_rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            mode_wr   <= 1'b0;
            interval  <= '0;
            win_start <= '0;
            win_range <= '0;
            pattern   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    en <= reg_wdata[CTL_EN_BIT];
                    if (!busy) begin
                        mode_wr  <= reg_wdata[CTL_MODE_BIT];
                        interval <= reg_wdata[CTL_IV_LSB +: IVW];
                    end
                end
                OFS_START: if (!busy) win_start <= reg_wdata[AW-1:0];
                OFS_RANGE: if (!busy) win_range <= reg_wdata[AW-1:0];
                OFS_PATT:  pattern <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTL_EN_BIT]             = en;
                reg_rdata[CTL_MODE_BIT]           = mode_wr;
                reg_rdata[CTL_IV_LSB +: IVW]      = interval;
            end
            OFS_STAT: begin
                reg_rdata[STA_BUSY_BIT] = busy;
                reg_rdata[STA_DONE_BIT] = done;
            end
            OFS_START: reg_rdata[AW-1:0] = win_start;
            OFS_RANGE: reg_rdata[AW-1:0] = win_range;
            OFS_PATT:  reg_rdata = pattern;
            default: ;
        endcase
    end

    // R8
    lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == OFS_START) |=> $stable(win_start));

    // R8
    lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == OFS_CTRL) |=> ($stable(mode_wr) && $stable(interval)));

endmodule

// File: rtl/scrub_pacer.sv
`timescale 1ns/1ps
module scrub_pacer #(
    parameter int IVW      = 8,
    parameter int PRESCALE = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [IVW-1:0] interval,
    output logic           pace_zero,
    output logic           pace_last
);

    localparam int GW = IVW + $clog2(PRESCALE + 1);

    logic [GW-1:0] gap_len;
    logic [GW-1:0] cnt;

    generate
        if (PRESCALE == 1) begin : g_unit
            assign gap_len = GW'(interval);
        end else begin : g_scaled
            assign gap_len = GW'(interval) * GW'(PRESCALE);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= gap_len;
        end else if (cnt != '0) begin
            cnt <= cnt - GW'(1);
        end
    end

    assign pace_zero = (interval == '0);
    assign pace_last = (cnt == GW'(1));

    // R6
    pace_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !load) |=> (cnt == $past(cnt) - GW'(1)));

endmodule

// File: rtl/scrub_track.sv
`timescale 1ns/1ps
module scrub_track #(
    parameter int MAX_OUT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic trk_full,
    output logic trk_empty
);

    localparam int CW = $clog2(MAX_OUT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign trk_full  = (cnt == CW'(MAX_OUT));
    assign trk_empty = (cnt == '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_OUT));

endmodule

// File: rtl/scrub_fsm.sv
`timescale 1ns/1ps
module scrub_fsm
    import scrub_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode_wr,
    input  logic [AW-1:0] win_start,
    input  logic [AW-1:0] win_range,
    input  logic          mem_ready,
    input  logic          trk_full,
    input  logic          trk_empty,
    input  logic          pace_zero,
    input  logic          pace_last,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          accept,
    output logic          pace_load,
    output logic          busy,
    output logic          done,
    output logic          host_hold
);

    scrub_state_t state, nxt;
    logic [AW-1:0] last_addr;
    logic          at_last;

    assign last_addr = win_start + win_range;
    assign at_last   = (mem_addr == last_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en) nxt = ST_ISSUE;
            ST_ISSUE: begin
                if (!en) begin
                    nxt = ST_DRAIN;
                end else if (accept) begin
                    if (mode_wr) begin
                        if (at_last) nxt = ST_DRAIN;
                    end else if (!pace_zero) begin
                        nxt = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (!en)            nxt = ST_DRAIN;
                else if (pace_last) nxt = ST_ISSUE;
            end
            ST_DRAIN: if (trk_empty) nxt = (done && en) ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (!en) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: begin
                busy    = 1'b1;
                mem_req = en && !trk_full;
            end
            ST_GAP:   busy = 1'b1;
            ST_DRAIN: busy = 1'b1;
            ST_HOLD:  ;
            default:  ;
        endcase
    end

    assign accept    = mem_req && mem_ready;
    assign pace_load = accept && !mode_wr && !pace_zero;
    assign host_hold = busy && mode_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            done     <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                mem_addr <= win_start;
            end else if (accept) begin
                mem_addr <= at_last ? win_start : mem_addr + AW'(1);
            end
            if (!en) begin
                done <= 1'b0;
            end else if (accept && mode_wr && at_last) begin
                done <= 1'b1;
            end
        end
    end

    // R7
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> en);

    // R4
    done_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> mode_wr);

    // R4
    busy_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> trk_empty);

    // R5
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - win_start) <= win_range));

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req && !mem_ready) && mem_req) |-> $stable(mem_addr));

    // R6
    gap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> !pace_zero);

endmodule

// File: rtl/scrub_engine.sv
`timescale 1ns/1ps
module scrub_engine
    import scrub_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 16,
    parameter int IVW      = 8,
    parameter int PRESCALE = 4,
    parameter int MAX_OUT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rsp,
    output logic              host_hold
);

    logic           en, mode_wr, busy, done;
    logic [IVW-1:0] interval;
    logic [AW-1:0]  win_start, win_range;
    logic [DW-1:0]  pattern;
    logic           accept, pace_load, pace_zero, pace_last;
    logic           trk_full, trk_empty;

    scrub_regs #(.DW(DW), .AW(AW), .IVW(IVW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .done      (done),
        .en        (en),
        .mode_wr   (mode_wr),
        .interval  (interval),
        .win_start (win_start),
        .win_range (win_range),
        .pattern   (pattern),
        .reg_rdata (reg_rdata)
    );

    scrub_pacer #(.IVW(IVW), .PRESCALE(PRESCALE)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pace_load),
        .interval  (interval),
        .pace_zero (pace_zero),
        .pace_last (pace_last)
    );

    scrub_track #(.MAX_OUT(MAX_OUT)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (accept),
        .dec       (mem_rsp),
        .trk_full  (trk_full),
        .trk_empty (trk_empty)
    );

    scrub_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode_wr   (mode_wr),
        .win_start (win_start),
        .win_range (win_range),
        .mem_ready (mem_ready),
        .trk_full  (trk_full),
        .trk_empty (trk_empty),
        .pace_zero (pace_zero),
        .pace_last (pace_last),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .accept    (accept),
        .pace_load (pace_load),
        .busy      (busy),
        .done      (done),
        .host_hold (host_hold)
    );

    assign mem_we    = mode_wr;
    assign mem_wdata = pattern;

endmodule

// File: tb/scrub_engine_bench.sv
`timescale 1ns/1ps
module scrub_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, host_hold;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b1;
    logic        mem_rsp = 1'b0;
    logic        ready_slow = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_count = 0;
    int acc_n = 0;
    int acc_cyc [0:255];
    logic [15:0] acc_addr [0:255];
    logic [31:0] mem [0:63];

    always #2.5 clk = ~clk;

    scrub_engine u_scrub_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rsp(mem_rsp), .host_hold(host_hold)
    );

    // memory model: one-cycle response per accepted request
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA5A5_0000 | 32'(i);
            mem_rsp <= 1'b0;
        end else begin
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr[5:0]] <= mem_wdata;
                    wr_count = wr_count + 1;
                end
                if (acc_n < 256) begin
                    acc_cyc[acc_n]  = cyc;
                    acc_addr[acc_n] = mem_addr;
                    acc_n = acc_n + 1;
                end
            end
            mem_rsp <= mem_req && mem_ready;
        end
    end

    always @(negedge clk) mem_ready <= ready_slow ? ~mem_ready : 1'b1;

    // fill table: base, inclusive offset, fill word, slow ready
    localparam logic [3:0][15:0] V_START = {16'd50, 16'd30, 16'd20, 16'd0};
    localparam logic [3:0][15:0] V_RANGE = {16'd13, 16'd12, 16'd0, 16'd7};
    localparam logic [3:0][31:0] V_PATT  = {32'hFFFF_FFFF, 32'h0F0F_1234, 32'hDEAD_BEEF, 32'h55AA_55AA};
    localparam logic [3:0]       V_SLOW  = 4'b0110;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // poll status until bit b equals val; returns status and hold seen then
    task automatic poll(input int b, input logic val, output logic [31:0] st, output logic hh);
        st = 32'd0; hh = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            reg_read(3'd1, st);
            hh = host_hold;
            if (st[b] == val) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, st;
        logic hh;
        int base_w, base_a, wc, bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(3'd1, d); check("R1 status", d, 32'd0);
        reg_read(3'd0, d); check("R1 ctrl", d, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 host_hold", {31'd0, host_hold}, 32'd0);

        // R2 control field layout
        reg_write(3'd0, 32'h0000_0314);
        reg_read(3'd0, d); check("R2 ctrl readback", d, 32'h0000_0304);
        reg_write(3'd0, 32'h0);
        reg_write(3'd4, 32'hCAFE_F00D);
        reg_read(3'd4, d); check("R2 fill word readback", d, 32'hCAFE_F00D);

        // fill-mode table (R3 R4 R9 R10)
        for (int v = 0; v < 4; v++) begin
            ready_slow = V_SLOW[v];
            reg_write(3'd2, {16'd0, V_START[v]});
            reg_write(3'd3, {16'd0, V_RANGE[v]});
            reg_write(3'd4, V_PATT[v]);
            reg_write(3'd0, 32'h14);
            base_w = wr_count;
            reg_write(3'd0, 32'h15);
            poll(1, 1'b1, st, hh);
            check("R4 done seen while busy", st, 32'h3);
            check("R9 hold during fill", {31'd0, hh}, 32'd1);
            poll(0, 1'b0, st, hh);
            check("R4 done held after busy falls", st, 32'h2);
            check("R9 hold low after drain", {31'd0, hh}, 32'd0);
            repeat (8) @(negedge clk);
            check("R10 R3 write count", 32'(wr_count - base_w), 32'(V_RANGE[v]) + 32'd1);
            bad = 0;
            for (int a = 0; a <= int'(V_RANGE[v]); a++)
                if (mem[int'(V_START[v]) + a] !== V_PATT[v]) bad++;
            check("R3 window contents", 32'(bad), 32'd0);
            if (V_START[v] > 0)
                check("R3 below window", mem[int'(V_START[v]) - 1], 32'hA5A5_0000 | (32'(V_START[v]) - 32'd1));
            if (int'(V_START[v]) + int'(V_RANGE[v]) < 63)
                check("R3 above window", mem[int'(V_START[v]) + int'(V_RANGE[v]) + 1],
                      32'hA5A5_0000 | (32'(V_START[v]) + 32'(V_RANGE[v]) + 32'd1));
            reg_write(3'd0, 32'h14);
            reg_read(3'd1, d); check("R4 done cleared by enable", d, 32'd0);
        end
        ready_slow = 1'b0;
        repeat (4) @(negedge clk);

        // R5 R6 R9 patrol with interval 1
        reg_write(3'd2, 32'd10);
        reg_write(3'd3, 32'd2);
        reg_write(3'd0, 32'h100);
        base_a = acc_n;
        reg_write(3'd0, 32'h101);
        repeat (10) @(negedge clk);
        check("R9 hold low in patrol", {31'd0, host_hold}, 32'd0);
        repeat (30) @(negedge clk);
        reg_write(3'd0, 32'h100);
        poll(0, 1'b0, st, hh);
        check("R7 patrol stop status", st, 32'd0);
        for (int i = 0; i < 6; i++)
            check("R5 patrol address", {16'd0, acc_addr[base_a + i]}, 32'd10 + 32'(i % 3));
        for (int i = 1; i < 6; i++)
            check("R6 interval 1 spacing", 32'(acc_cyc[base_a + i] - acc_cyc[base_a + i - 1]), 32'd5);

        // R6 interval 0 back-to-back
        reg_write(3'd2, 32'd5);
        reg_write(3'd3, 32'd1);
        base_a = acc_n;
        reg_write(3'd0, 32'h001);
        repeat (6) @(negedge clk);
        reg_write(3'd0, 32'h000);
        poll(0, 1'b0, st, hh);
        for (int i = 0; i < 4; i++)
            check("R5 wrap two-word window", {16'd0, acc_addr[base_a + i]}, 32'd5 + 32'(i % 2));
        for (int i = 1; i < 4; i++)
            check("R6 interval 0 spacing", 32'(acc_cyc[base_a + i] - acc_cyc[base_a + i - 1]), 32'd1);

        // R7 abort mid-fill
        ready_slow = 1'b1;
        reg_write(3'd2, 32'd0);
        reg_write(3'd3, 32'd60);
        reg_write(3'd4, 32'h1234_5678);
        reg_write(3'd0, 32'h14);
        base_w = wr_count;
        reg_write(3'd0, 32'h15);
        repeat (10) @(negedge clk);
        reg_write(3'd0, 32'h04);
        wc = wr_count;
        check("R7 req low after abort", {31'd0, mem_req}, 32'd0);
        repeat (10) @(negedge clk);
        check("R7 no writes after abort", 32'(wr_count), 32'(wc));
        check("R7 partial fill", {31'd0, (wr_count - base_w) < 61}, 32'd1);
        poll(0, 1'b0, st, hh);
        check("R7 done stays low", st, 32'd0);
        ready_slow = 1'b0;

        // R8 lock while busy
        reg_write(3'd2, 32'd10);
        reg_write(3'd3, 32'd2);
        reg_write(3'd0, 32'h200);
        base_a = acc_n;
        reg_write(3'd0, 32'h201);
        repeat (3) @(negedge clk);
        reg_write(3'd2, 32'd40);
        reg_write(3'd3, 32'd5);
        reg_write(3'd0, 32'h505);
        reg_read(3'd2, d); check("R8 base locked", d, 32'd10);
        reg_read(3'd3, d); check("R8 offset locked", d, 32'd2);
        reg_read(3'd0, d); check("R8 mode and interval locked", d, 32'h201);
        check("R9 hold low with ignored mode", {31'd0, host_hold}, 32'd0);
        repeat (40) @(negedge clk);
        reg_write(3'd0, 32'h200);
        poll(0, 1'b0, st, hh);
        check("R8 enable writable while busy", st, 32'd0);
        bad = 0;
        for (int i = base_a; i < acc_n; i++)
            if (acc_addr[i] < 16'd10 || acc_addr[i] > 16'd12) bad++;
        check("R8 reads stayed in locked window", 32'(bad), 32'd0);
        check("R8 reads issued", {31'd0, (acc_n - base_a) >= 3}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule